// File: doc/BRIEF.md
# Low-Power Mode Controller

This block decides when the core supply rail goes into and comes out of a deep-sleep state. A sleep request pin is qualified by a sleep-enable configuration bit. The block enters sleep only on a rising edge of the two ANDed together. While asleep it drives a preset reduced voltage code to the core converter, or switches the core off when a core-off configuration bit is set.

The block leaves sleep when any one of four things happens: the request pin drops, the enable bit is cleared, a push-button event arrives, or a hot-reset event arrives. On leaving, it restores the voltage code that was in use before entry. The running voltage code sits in a holding register. Software writes through a write strobe update that register only while the block is awake, so the pre-sleep value survives the whole sleep period.

A push-button event also sets a sticky interrupt flag, unless that flag is masked. Software clears the flag by writing one. The configuration bits and the already-debounced push-button and hot-reset pulses arrive as plain inputs.

Top module: `lp_mode_ctrl`

## Requirements
- R1: Sleep (`lp_active` = 1) is entered one clock after a cycle in which `lp_req AND lp_en` is 1 and was 0 in the previous cycle. No entry happens if `pb_evt` or `hr_evt` is 1 in that same cycle.
- R2: While `lp_en` is 0, `lp_req` has no effect on `lp_active`.
- R3: While asleep, each of the following clears `lp_active` at the next clock: `lp_req` = 0, `lp_en` = 0, `pb_evt` = 1 or `hr_evt` = 1. Several of these in the same cycle give one single exit.
- R4: While asleep, `core_vcode` equals `lp_vcode`, and `core_en` is the inverse of `core_off`. While awake, `core_en` is 1.
- R5: A write (`vcode_wr` = 1) loads `vcode_wdata` into the holding register at the next clock, but only while awake. A write made while asleep is discarded. While awake, `core_vcode` shows the holding register, so after an exit it shows the pre-entry code.
- R6: After an exit, the block does not sleep again until `lp_req AND lp_en` shows a new rising edge. Either the pin or the enable bit can be toggled to make that edge.
- R7: A `pb_evt` with `pb_irq_mask` = 0 sets `pb_irq` at the next clock, whether asleep or awake. With `pb_irq_mask` = 1 the event does not set it.
- R8: `pb_irq` stays set until a cycle with `irq_clr` = 1. A new unmasked `pb_evt` in that same cycle wins over the clear.
- R9: Synchronous reset (`rst_n` = 0) gives `lp_active` = 0, holding code = `RST_VCODE`, `pb_irq` = 0 and `core_en` = 1. It also clears the edge history, so a request that is already high when reset is released counts as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lp_req | input | 1 | Sleep request pin |
| lp_en | input | 1 | Sleep enable configuration bit |
| core_off | input | 1 | 1 = core switched off while asleep |
| lp_vcode | input | VCODE_W | Reduced voltage code used while asleep |
| vcode_wr | input | 1 | Write strobe for the running voltage code |
| vcode_wdata | input | VCODE_W | Running voltage code to write |
| pb_evt | input | 1 | Debounced push-button event pulse |
| hr_evt | input | 1 | Debounced hot-reset event pulse |
| pb_irq_mask | input | 1 | 1 = push-button interrupt masked |
| irq_clr | input | 1 | Write-one-to-clear for the interrupt flag |
| core_vcode | output | VCODE_W | Voltage code applied to the core converter |
| core_en | output | 1 | Core converter enable |
| lp_active | output | 1 | Sleep state flag |
| pb_irq | output | 1 | Sticky push-button interrupt flag |

## Verification
The bench looks for re-entry without a fresh edge, for example after a push-button exit while the request and enable stay high. A level-sensitive design would drop straight back into sleep there. It writes a new voltage code during sleep and checks that the exit still restores the pre-entry code. A design that lets such a write through would come out at the wrong voltage. It also fires a rising edge together with a push-button event, fires push-button and hot-reset together, and sends a set and a clear in the same cycle. A design with the wrong priority in any of these would enter sleep anyway, give two exits, or lose an interrupt. Finally it releases reset with the request already high. A design whose edge history survives reset would miss that entry.

// File: rtl/lp_pkg.sv
// Package: shared types for the low-power mode controller.
// Assumes: nothing beyond the standard language.
package lp_pkg;
    typedef enum logic {
        LP_RUN   = 1'b0,
        LP_SLEEP = 1'b1
    } lp_state_e;
endpackage

// File: rtl/lp_edge_detect.sv
// lp_edge_detect: qualifies the sleep request pin with the enable bit and
// flags a rising edge of the combined signal.
// Assumes: inputs are synchronous to clk; history cleared by reset.
module lp_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic lp_req,
    input  logic lp_en,
    output logic rise
);
    logic qual;
    logic qual_q;

    // Request only counts when enabled (R2).
    assign qual = lp_req & lp_en;

    // Keep last cycle's qualified request for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) qual_q <= 1'b0;
        else        qual_q <= qual;
    end

    // Rising edge of the qualified request (R1, R6).
    assign rise = qual & ~qual_q;
endmodule

// File: rtl/lp_state_ctrl.sv
// lp_state_ctrl: two-state sleep controller; enters on a qualified edge,
// leaves on any of four exit causes.
// Assumes: rise comes from lp_edge_detect; events are single-cycle pulses.
module lp_state_ctrl
    import lp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic lp_req,
    input  logic lp_en,
    input  logic pb_evt,
    input  logic hr_evt,
    output logic lp_active
);
    lp_state_e state_q;
    lp_state_e state_d;
    logic      exit_any;
    logic      evt_any;

    assign evt_any  = pb_evt | hr_evt;
    // Any one cause, or several together, gives one exit (R3).
    assign exit_any = ~lp_req | ~lp_en | evt_any;

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        case (state_q)
            LP_RUN:   if (rise && !evt_any) state_d = LP_SLEEP;
            LP_SLEEP: if (exit_any)         state_d = LP_RUN;
            default:  state_d = LP_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LP_RUN;
        else        state_q <= state_d;
    end

    assign lp_active = (state_q == LP_SLEEP);

    // Entry needs the qualified request high in the previous cycle.
    assert_entry_qualified_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_active && !$past(lp_active)) |-> $past(lp_req && lp_en && !pb_evt && !hr_evt));

    // Any exit cause while asleep gives an exit at the next clock.
    assert_exit_next_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_active && (!lp_req || !lp_en || pb_evt || hr_evt)) |=> !lp_active);
endmodule

// File: rtl/lp_vcode_hold.sv
// lp_vcode_hold: holding register for the running core voltage code.
// Writes are taken only while awake, so the pre-entry code is kept.
// Assumes: lp_active is registered state from lp_state_ctrl.
module lp_vcode_hold #(
    parameter int                 VCODE_W   = 6,
    parameter logic [VCODE_W-1:0] RST_VCODE = VCODE_W'(20)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lp_active,
    input  logic               vcode_wr,
    input  logic [VCODE_W-1:0] vcode_wdata,
    output logic [VCODE_W-1:0] run_vcode
);
    // Update on awake writes; hold through sleep (R5).
    always_ff @(posedge clk) begin
        if (!rst_n)                      run_vcode <= RST_VCODE;
        else if (vcode_wr && !lp_active) run_vcode <= vcode_wdata;
    end

    // The held code is frozen while asleep.
    assert_hold_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lp_active |=> $stable(run_vcode));
endmodule

// File: rtl/lp_pb_irq.sv
// lp_pb_irq: sticky, maskable push-button interrupt flag with
// write-one-to-clear; a new event wins over a clear.
// Assumes: pb_evt is a single-cycle debounced pulse.
module lp_pb_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic pb_evt,
    input  logic pb_irq_mask,
    input  logic irq_clr,
    output logic pb_irq
);
    logic set_req;

    assign set_req = pb_evt & ~pb_irq_mask;

    // Set has priority over clear (R7, R8).
    always_ff @(posedge clk) begin
        if (!rst_n)       pb_irq <= 1'b0;
        else if (set_req) pb_irq <= 1'b1;
        else if (irq_clr) pb_irq <= 1'b0;
    end

    // Unmasked event always shows up as an interrupt.
    assert_irq_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pb_evt && !pb_irq_mask) |=> pb_irq);

    // Flag holds until cleared.
    assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pb_irq && !irq_clr) |=> pb_irq);
endmodule

// File: rtl/lp_mode_ctrl.sv
// lp_mode_ctrl: top of the low-power mode controller. Drives the core
// voltage code and enable from sleep state, the reduced code and the
// held running code.
// Assumes: configuration bits are static register outputs; event pulses
// are already debounced and synchronous.
module lp_mode_ctrl #(
    parameter int                 VCODE_W   = 6,
    parameter logic [VCODE_W-1:0] RST_VCODE = VCODE_W'(20)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lp_req,
    input  logic               lp_en,
    input  logic               core_off,
    input  logic [VCODE_W-1:0] lp_vcode,
    input  logic               vcode_wr,
    input  logic [VCODE_W-1:0] vcode_wdata,
    input  logic               pb_evt,
    input  logic               hr_evt,
    input  logic               pb_irq_mask,
    input  logic               irq_clr,
    output logic [VCODE_W-1:0] core_vcode,
    output logic               core_en,
    output logic               lp_active,
    output logic               pb_irq
);
    logic               rise;
    logic [VCODE_W-1:0] run_vcode;

    lp_edge_detect u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lp_req (lp_req),
        .lp_en  (lp_en),
        .rise   (rise)
    );

    lp_state_ctrl u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise      (rise),
        .lp_req    (lp_req),
        .lp_en     (lp_en),
        .pb_evt    (pb_evt),
        .hr_evt    (hr_evt),
        .lp_active (lp_active)
    );

    lp_vcode_hold #(
        .VCODE_W   (VCODE_W),
        .RST_VCODE (RST_VCODE)
    ) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .lp_active   (lp_active),
        .vcode_wr    (vcode_wr),
        .vcode_wdata (vcode_wdata),
        .run_vcode   (run_vcode)
    );

    lp_pb_irq u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .pb_evt      (pb_evt),
        .pb_irq_mask (pb_irq_mask),
        .irq_clr     (irq_clr),
        .pb_irq      (pb_irq)
    );

    // Output selection: reduced code / off while asleep, held code awake (R4, R5).
    always_comb begin
        core_vcode = lp_active ? lp_vcode : run_vcode;
        core_en    = ~(lp_active & core_off);
    end
endmodule

// File: tb/tb_lp_mode_ctrl.sv
module tb_lp_mode_ctrl;
    localparam int          W    = 6;
    localparam logic [W-1:0] RSTV = 6'd20;
    localparam logic [W-1:0] LPV  = 6'd8;
    localparam int          NV   = 26;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         lp_req = 0, lp_en = 0, core_off = 0, vcode_wr = 0;
    logic [W-1:0] vcode_wdata = '0;
    logic         pb_evt = 0, hr_evt = 0, pb_irq_mask = 0, irq_clr = 0;
    logic [W-1:0] core_vcode;
    logic         core_en, lp_active, pb_irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;  // 50 MHz

    lp_mode_ctrl #(.VCODE_W(W), .RST_VCODE(RSTV)) dut (
        .clk(clk), .rst_n(rst_n), .lp_req(lp_req), .lp_en(lp_en),
        .core_off(core_off), .lp_vcode(LPV), .vcode_wr(vcode_wr),
        .vcode_wdata(vcode_wdata), .pb_evt(pb_evt), .hr_evt(hr_evt),
        .pb_irq_mask(pb_irq_mask), .irq_clr(irq_clr),
        .core_vcode(core_vcode), .core_en(core_en),
        .lp_active(lp_active), .pb_irq(pb_irq)
    );

    // Vector: {req,en,off,pb,hr,mask,clr,wr}, wdata, then expected
    // lp_active, core_vcode, core_en, pb_irq one clock later.
    localparam logic [22:0] VEC [NV] = '{
        {8'b00000001, 6'd30, 1'b0, 6'd30, 1'b1, 1'b0}, //  0 R5 awake write
        {8'b10000000, 6'd0,  1'b0, 6'd30, 1'b1, 1'b0}, //  1 R2 pin ignored
        {8'b11000000, 6'd0,  1'b1, 6'd8,  1'b1, 1'b0}, //  2 R1 enter
        {8'b11000001, 6'd40, 1'b1, 6'd8,  1'b1, 1'b0}, //  3 R5 write dropped
        {8'b01000000, 6'd0,  1'b0, 6'd30, 1'b1, 1'b0}, //  4 R3 pin low exit
        {8'b11000000, 6'd0,  1'b1, 6'd8,  1'b1, 1'b0}, //  5 R6 pin toggle
        {8'b11100000, 6'd0,  1'b1, 6'd8,  1'b0, 1'b0}, //  6 R4 core off
        {8'b11010000, 6'd0,  1'b0, 6'd30, 1'b1, 1'b1}, //  7 R3 R7 pb exit
        {8'b11000000, 6'd0,  1'b0, 6'd30, 1'b1, 1'b1}, //  8 R6 no re-entry
        {8'b11000010, 6'd0,  1'b0, 6'd30, 1'b1, 1'b0}, //  9 R8 clear
        {8'b10000000, 6'd0,  1'b0, 6'd30, 1'b1, 1'b0}, // 10 enable low
        {8'b11000000, 6'd0,  1'b1, 6'd8,  1'b1, 1'b0}, // 11 R6 enable toggle
        {8'b10000000, 6'd0,  1'b0, 6'd30, 1'b1, 1'b0}, // 12 R3 enable exit
        {8'b11000000, 6'd0,  1'b1, 6'd8,  1'b1, 1'b0}, // 13 enter
        {8'b11001000, 6'd0,  1'b0, 6'd30, 1'b1, 1'b0}, // 14 R3 hot-reset exit
        {8'b01000000, 6'd0,  1'b0, 6'd30, 1'b1, 1'b0}, // 15
        {8'b11000000, 6'd0,  1'b1, 6'd8,  1'b1, 1'b0}, // 16 enter
        {8'b11010100, 6'd0,  1'b0, 6'd30, 1'b1, 1'b0}, // 17 R7 masked pb exit
        {8'b00000000, 6'd0,  1'b0, 6'd30, 1'b1, 1'b0}, // 18
        {8'b11000000, 6'd0,  1'b1, 6'd8,  1'b1, 1'b0}, // 19 enter
        {8'b00011000, 6'd0,  1'b0, 6'd30, 1'b1, 1'b1}, // 20 R3 all causes
        {8'b00010010, 6'd0,  1'b0, 6'd30, 1'b1, 1'b1}, // 21 R8 set wins
        {8'b00000010, 6'd0,  1'b0, 6'd30, 1'b1, 1'b0}, // 22 R8 clear
        {8'b00000001, 6'd12, 1'b0, 6'd12, 1'b1, 1'b0}, // 23 R5 write
        {8'b11010100, 6'd0,  1'b0, 6'd12, 1'b1, 1'b0}, // 24 R1 edge with pb
        {8'b11000000, 6'd0,  1'b0, 6'd12, 1'b1, 1'b0}  // 25 R6 edge used up
    };

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: {act,vcode,en,irq} actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic drive(input logic [7:0] c, input logic [W-1:0] wd);
        {lp_req, lp_en, core_off, pb_evt, hr_evt, pb_irq_mask, irq_clr, vcode_wr} = c;
        vcode_wdata = wd;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R9 reset state
        check("R9", {lp_active, core_vcode, core_en, pb_irq}, {1'b0, RSTV, 1'b1, 1'b0});
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i][22:15], VEC[i][14:9]);
            @(posedge clk); #1;
            check($sformatf("R-vec%0d", i), {lp_active, core_vcode, core_en, pb_irq}, VEC[i][8:0]);
        end

        // R9: reset while asleep returns to the reset state
        @(negedge clk); drive(8'b00000000, '0);
        @(negedge clk); drive(8'b11000000, '0);
        @(posedge clk); #1;
        check("R1", {lp_active, core_vcode}, {1'b1, LPV});
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        check("R9", {lp_active, core_vcode, core_en, pb_irq}, {1'b0, RSTV, 1'b1, 1'b0});
        // R9: request high across reset release counts as an edge
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R9", {lp_active, core_vcode, core_en, pb_irq}, {1'b1, LPV, 1'b1, 1'b0});
        // R7: unmasked push-button while awake sets the flag, no sleep
        @(negedge clk); drive(8'b00000000, '0);
        @(negedge clk); drive(8'b00010000, '0);
        @(posedge clk); #1;
        check("R7", {lp_active, core_vcode, core_en, pb_irq}, {1'b0, RSTV, 1'b1, 1'b1});
        @(negedge clk); drive(8'b00000000, '0);
        @(posedge clk); #1;
        check("R8", {8'b0, pb_irq}, 9'b1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule